// File: doc/BRIEF.md
# Counting Level-Sensitive Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt lines (64 by default) onto one parent interrupt output. Each line is brought into the clock domain through a two-stage synchroniser. The result is held as that line's sampled level, and each line has its own enable bit. The controller does not expose a pending bitmap. It reports a live count of lines that are both high and enabled, and it raises the parent interrupt whenever that count is non-zero.

Software reaches the block through a small synchronous register bus. A word index is taken from address bits [11:2] of a 4 KB window. Software can read an identity constant, the pending count, and the lowest-numbered active line. Lines are switched on or off one at a time by writing the line number to a command register. A further command switches every line off at once. Read data appears one clock after the read strobe.

Top module: `lvl_irq_counter`

## Requirements
- R1: The word index is bus_addr[11:2]. A read of index 0 returns the parameter ID_WORD.
- R2: A read of index 1 returns the number of lines whose sampled level is high and whose enable bit is set. A level change on a disabled line leaves this number unchanged.
- R3: irq_o is high exactly when the pending count is greater than zero.
- R4: A read of index 2 returns the lowest line number that is both high and enabled. If no line is, it returns 0xFFFFFFFF.
- R5: Any write to index 3 clears every enable bit, so the pending count becomes zero.
- R6: A write of value v to index 4 clears the enable bit of line v. Repeating it on a line that is already off changes nothing.
- R7: A write of value v to index 5 sets the enable bit of line v. Repeating it on a line that is already on changes nothing.
- R8: Writes to index 4 or 5 are ignored when the full 32-bit value is greater than or equal to NUM_SRC. Such a value is never truncated onto a lower line.
- R9: After reset every line is disabled, every sampled level is low, the count is 0 and irq_o is low.
- R10: A read of any index above 5 returns 0. Writes to indices 0, 1, 2 and to any index above 5 have no effect.
- R11: A change on src_i reaches the sampled level through two flip-flops. irq_o reacts after the second rising edge and not after the first.
- R12: bus_rdata carries the addressed value on the rising edge that samples bus_rd, and holds it while no read is strobed.
- R13: When a line's sampled level and its enable bit change on the same edge, the count afterwards matches the new levels and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq_o | output | 1 | Parent interrupt, high while the count is non-zero |

## Verification
The hardest case to reach from the ports is a line whose synchronised level and enable bit change on the same clock edge. A counter updated by increments would lose or double that event. The bench drives the line high at a falling edge, lets one rising edge pass so the first synchroniser stage captures it, and then issues the enable write so that it lands on the second edge, together with the level. It repeats the timing with the line falling while a disable write lands. Out-of-range indices such as 64 and 0xFFFFFFFF are written while line 0 is high, so a truncated index would show up as a changed lowest-line read.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int REG_W      = 32;
  localparam int IDX_W      = 10;
  localparam int IDX_ID     = 0;
  localparam int IDX_COUNT  = 1;
  localparam int IDX_LOWEST = 2;
  localparam int IDX_OFFALL = 3;
  localparam int IDX_OFF    = 4;
  localparam int IDX_ON     = 5;
  localparam logic [REG_W-1:0] NONE_ACTIVE = '1;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= d_i;
      lvl_q  <= meta_q;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/lic_enable_bank.sv
module lic_enable_bank
  import lic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [NUM_SRC-1:0] en_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] en_q, en_d;
  logic               in_range;
  logic [SEL_W-1:0]   sel;

  assign in_range = (wdata_i < REG_W'(NUM_SRC));
  assign sel      = wdata_i[SEL_W-1:0];

  always_comb begin
    en_d = en_q;
    if (idx_i == IDX_W'(IDX_OFFALL)) begin
      en_d = '0;
    end else if (in_range && idx_i == IDX_W'(IDX_OFF)) begin
      en_d[sel] = 1'b0;
    end else if (in_range && idx_i == IDX_W'(IDX_ON)) begin
      en_d[sel] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

  assert_offall_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && idx_i == IDX_W'(IDX_OFFALL)) |=> (en_q == '0));

  assert_off_clears_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && in_range && idx_i == IDX_W'(IDX_OFF)) |=> !en_q[$past(sel)]);

  assert_on_sets_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && in_range && idx_i == IDX_W'(IDX_ON)) |=> en_q[$past(sel)]);

  assert_oob_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !in_range && (idx_i == IDX_W'(IDX_ON) || idx_i == IDX_W'(IDX_OFF)))
      |=> $stable(en_q));
endmodule

// File: rtl/lic_scan.sv
module lic_scan
  import lic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           lvl_i,
  input  logic [NUM_SRC-1:0]           en_i,
  output logic [$clog2(NUM_SRC+1)-1:0] count_o,
  output logic [REG_W-1:0]             lowest_o
);
  localparam int CNT_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] act;
  assign act = lvl_i & en_i;

  always_comb begin
    count_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      count_o = count_o + CNT_W'(act[i]);
    end
  end

  always_comb begin
    lowest_o = NONE_ACTIVE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act[i]) lowest_o = REG_W'(i);
    end
  end

  assert_none_iff_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lowest_o == NONE_ACTIVE) == (count_o == '0));

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(NUM_SRC));
endmodule

// File: rtl/lvl_irq_counter.sv
module lvl_irq_counter
  import lic_pkg::*;
#(
  parameter int          NUM_SRC = 64,
  parameter logic [31:0] ID_WORD = 32'hC0DE_1A70
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [11:0]        bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  localparam int CNT_W = $clog2(NUM_SRC + 1);

  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] en;
  logic [CNT_W-1:0]   count;
  logic [REG_W-1:0]   lowest;
  logic [REG_W-1:0]   rdata_q, rdata_d;

  assign idx = bus_addr[11:2];

  lic_sync #(.W(NUM_SRC)) u_sync (
    .clk (clk), .rst_n (rst_n), .d_i (src_i), .q_o (lvl)
  );

  lic_enable_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk (clk), .rst_n (rst_n), .wr_i (bus_wr), .idx_i (idx),
    .wdata_i (bus_wdata), .en_o (en)
  );

  lic_scan #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk (clk), .rst_n (rst_n), .lvl_i (lvl), .en_i (en),
    .count_o (count), .lowest_o (lowest)
  );

  always_comb begin
    case (idx)
      IDX_W'(IDX_ID):     rdata_d = ID_WORD;
      IDX_W'(IDX_COUNT):  rdata_d = REG_W'(count);
      IDX_W'(IDX_LOWEST): rdata_d = lowest;
      default:            rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = (count != '0);

  assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IDX_W'(IDX_ID)) |=> (bus_rdata == ID_WORD));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx > IDX_W'(IDX_ON)) |=> (bus_rdata == '0));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_irq_vs_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (lowest != NONE_ACTIVE));
endmodule

// File: tb/sim_lvl_irq_counter.sv
module sim_lvl_irq_counter;
  localparam int N = 64;
  localparam logic [31:0] ID = 32'hC0DE_1A70;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [N-1:0] lvl_m = '0;
  logic [N-1:0] en_m = '0;

  lvl_irq_counter #(.NUM_SRC(N), .ID_WORD(ID)) u0 (
    .clk (clk), .rst_n (rst_n), .src_i (src_i), .bus_addr (bus_addr),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq_o (irq_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_count();
    logic [31:0] c = 0;
    for (int i = 0; i < N; i++) c += 32'(lvl_m[i] & en_m[i]);
    return c;
  endfunction

  function automatic logic [31:0] m_lowest();
    for (int i = 0; i < N; i++) if (lvl_m[i] & en_m[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  // driver: called at a falling edge, returns at a falling edge
  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    bus_addr = 12'(idx << 2);
    bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] val);
    bus_addr = 12'(idx << 2);
    bus_wdata = val;
    bus_wr = 1'b1;
    if (idx == 3) en_m = '0;
    else if (idx == 4 && val < N) en_m[val[5:0]] = 1'b0;
    else if (idx == 5 && val < N) en_m[val[5:0]] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_src(input logic [N-1:0] v);
    src_i = v;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    lvl_m = v;
  endtask

  task automatic status(input string tag);
    rd(1, m_count(), tag);
    rd(2, m_lowest(), tag);
    check({tag, " irq"}, 32'(irq_o), 32'(m_count() != 0));
  endtask

  // monitor: pops an expected item for each read the design has taken
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R12: unexpected read data actual %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 irq after reset", 32'(irq_o), 32'd0);
    rd(1, 0, "R9 count after reset");
    rd(2, 32'hFFFF_FFFF, "R9 lowest after reset");
    // R1 / R12 identity read, one-cycle latency
    rd(0, ID, "R1 R12 identity");
    // R2 levels on disabled lines do not count
    set_src('1);
    status("R2 disabled lines high");
    // R7 enable 9 and 5
    wr(5, 9); wr(5, 5);
    status("R7 R3 R4 two enabled");
    wr(5, 5);
    status("R7 repeat enable");
    // R6 disable
    wr(4, 5);
    status("R6 disable 5");
    wr(4, 5);
    status("R6 repeat disable");
    // R8 out-of-range indices, line 0 high and off
    wr(5, 64); wr(5, 32'hFFFF_FFFF); wr(4, 32'h0000_0049);
    status("R8 out of range ignored");
    // R10 writes to read-only/unmapped, reads of unmapped
    wr(0, 5); wr(1, 0); wr(2, 0); wr(9, 0); wr(1023, 0);
    status("R10 read-only writes ignored");
    rd(6, 0, "R10 unmapped 6");
    rd(1023, 0, "R10 unmapped 1023");
    // R11 two-stage latency: drop line 9
    src_i[9] = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 irq after one edge", 32'(irq_o), 32'd1);
    @(posedge clk); @(negedge clk);
    lvl_m = src_i;
    check("R11 irq after two edges", 32'(irq_o), 32'd0);
    status("R2 R3 line dropped");
    // boundary lines
    wr(5, 63);
    status("R4 line 63");
    wr(5, 0);
    status("R4 line 0");
    // R5 disable all
    wr(3, 0);
    status("R5 disable all");
    wr(5, 33);
    status("R5 re-enable after clear");
    // R13 level rises on the edge that lands the enable write
    set_src('0);
    status("R13 setup");
    src_i[20] = 1'b1;
    @(posedge clk); @(negedge clk);
    wr(5, 20);
    lvl_m = src_i;
    status("R13 rise with enable");
    src_i[20] = 1'b0;
    @(posedge clk); @(negedge clk);
    wr(4, 20);
    lvl_m = src_i;
    status("R13 fall with disable");
    // varied pattern
    wr(5, 40); wr(5, 41); wr(5, 2);
    set_src(64'h0000_0300_0000_0004);
    status("R2 pattern");
    set_src(64'h0000_0200_0000_0000);
    status("R2 R4 pattern 2");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule